// File: doc/BRIEF.md
# Prioritized Interrupt Vector Register

This block merges the pending-event flags of a timer's secondary interrupt sources into one vector word. There are three sources: compare channels 1 and 2 and the counter overflow. The compare channel 0 event has its own dedicated vector, so it has no input here and is never reported. Each flag is qualified by its enable. The vector presents an even code that names the highest-priority source that is both pending and enabled.

A read strobe clears the flag of the source being reported, and no other flag. Software can therefore read in a loop until the word returns zero, and it services every qualified source in priority order. Flags are set by single-cycle hardware event pulses. Flags can also be set or cleared directly through write ports. The interrupt request is the OR of all qualified flags.

Top module: `ivr_vector_reg`

## Requirements
- R1: While reset is held, and in the first cycle after it, all flags are 0, the vector is 0 and the request is low.
- R2: The vector reads 0 whenever no flag is both set and enabled.
- R3: Flag bit positions are fixed: bit 0 is compare channel 1, bit 1 is compare channel 2 and bit 2 is overflow. The codes they report are 2, 4 and 10 respectively.
- R4: Priority runs from compare channel 1 (highest) through compare channel 2 to overflow (lowest).
- R5: A read clears only the flag that the vector reports in that cycle. The clear is visible after the next rising edge. All other flags keep their value.
- R6: Repeated reads return the qualified sources in priority order, then 0.
- R7: A set flag whose enable is low is not reported, is not cleared by a read, and does not raise the request.
- R8: The request is combinational from the flags and enables. It falls in the cycle after the read that clears the last qualified flag.
- R9: A hardware set pulse on the same edge as a read-clear or a write-clear of that flag leaves the flag set.
- R10: Write-set and write-clear act on any flag independently of reads. A write-set beats a write-clear on the same bit.
- R11: A read while the vector is 0 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_set_i | input | 3 | Hardware event pulses, one per source |
| src_ien_i | input | 3 | Per-source interrupt enables |
| wr_set_i | input | 3 | Direct flag set |
| wr_clr_i | input | 3 | Direct flag clear |
| rd_stb_i | input | 1 | Vector read strobe; clears the reported flag |
| vec_o | output | 4 | Current vector code (0, 2, 4 or 10) |
| flags_o | output | 3 | Raw pending flags |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The vector code and the request follow the flags and enables in the same cycle. The bench drives inputs just after a falling edge and compares both outputs 1 ns later, before the rising edge that acts on those inputs. Flag changes caused by event pulses, writes or a read take effect at the next rising edge. The bench checks them at the following falling edge against a model that it advances once per cycle. Directed cases cover the read walk, masked flags and set/clear collisions. Random cycles with a fixed seed cover the rest.

// File: rtl/ivr_pkg.sv
// Package: shared helpers for the interrupt vector register.
// Assumes compare channels take codes 2,4,.. and overflow takes a larger code.
package ivr_pkg;

    // Code reported for source index idx (channels first, overflow last)
    function automatic int unsigned src_code(int unsigned idx, int unsigned n_ch,
                                             int unsigned ovf_code);
        return (idx < n_ch) ? 2 * (idx + 1) : ovf_code;
    endfunction

endpackage

// File: rtl/ivr_prio_pick.sv
// Module: fixed-priority one-hot picker, lowest index wins.
// Assumes req is already qualified by enables.
module ivr_prio_pick #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    logic [N:0] blocked;

    assign blocked[0] = 1'b0;

    // Per-source grant: pending and nothing higher pending
    for (genvar g = 0; g < N; g++) begin : g_pick
        assign grant[g]     = req[g] & ~blocked[g];
        assign blocked[g+1] = blocked[g] | req[g];
    end

    assign any = blocked[N];
endmodule

// File: rtl/ivr_code_map.sv
// Module: turns a one-hot grant into the even vector code.
// Assumes grant is one-hot or zero; zero maps to code 0.
module ivr_code_map
    import ivr_pkg::*;
#(
    parameter int NSRC     = 3,
    parameter int NCH      = 2,
    parameter int OVF_CODE = 10,
    parameter int VW       = 4
) (
    input  logic [NSRC-1:0] grant,
    output logic [VW-1:0]   code
);
    // OR together the code of the granted source
    always_comb begin
        code = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) code = code | VW'(src_code(i, NCH, OVF_CODE));
        end
    end
endmodule

// File: rtl/ivr_flag_bank.sv
// Module: pending-flag storage, one register per source.
// Assumes set inputs beat every clear input on the same bit.
module ivr_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hw_set,
    input  logic [N-1:0] sw_set,
    input  logic [N-1:0] sw_clr,
    input  logic [N-1:0] rd_clr,
    output logic [N-1:0] flags
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // Flag update: clear first, then any set overrides
        always_ff @(posedge clk) begin
            if (!rst_n) flags[g] <= 1'b0;
            else        flags[g] <= (flags[g] & ~(sw_clr[g] | rd_clr[g]))
                                    | hw_set[g] | sw_set[g];
        end
    end
endmodule

// File: rtl/ivr_vector_reg.sv
// Module: prioritized interrupt vector word for timer channels 1..NUM_CH plus overflow.
// Assumes event pulses are synchronous to clk; channel 0 is handled elsewhere.
module ivr_vector_reg #(
    parameter int NUM_CH   = 2,
    parameter int OVF_CODE = 10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CH:0]                src_set_i,
    input  logic [NUM_CH:0]                src_ien_i,
    input  logic [NUM_CH:0]                wr_set_i,
    input  logic [NUM_CH:0]                wr_clr_i,
    input  logic                           rd_stb_i,
    output logic [$clog2(OVF_CODE+1)-1:0]  vec_o,
    output logic [NUM_CH:0]                flags_o,
    output logic                           irq_o
);
    localparam int NSRC = NUM_CH + 1;
    localparam int VW   = $clog2(OVF_CODE + 1);

    logic [NSRC-1:0] flags, qual, grant, rd_clr;
    logic            any;

    // Qualify pending flags with enables
    assign qual = flags & src_ien_i;

    ivr_prio_pick #(.N(NSRC)) u_pick (
        .req   (qual),
        .grant (grant),
        .any   (any)
    );

    // Read side effect: clear only the granted source
    assign rd_clr = rd_stb_i ? grant : '0;

    ivr_flag_bank #(.N(NSRC)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set (src_set_i),
        .sw_set (wr_set_i),
        .sw_clr (wr_clr_i),
        .rd_clr (rd_clr),
        .flags  (flags)
    );

    ivr_code_map #(
        .NSRC     (NSRC),
        .NCH      (NUM_CH),
        .OVF_CODE (OVF_CODE),
        .VW       (VW)
    ) u_map (
        .grant (grant),
        .code  (vec_o)
    );

    assign flags_o = flags;
    assign irq_o   = any;
endmodule

// File: rtl/ivr_vector_reg_chk.sv
// Module: property checker for ivr_vector_reg, attached by bind.
// Assumes the default three-source configuration widths.
module ivr_vector_reg_chk #(
    parameter int NSRC = 3,
    parameter int VW   = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_set_i,
    input logic [NSRC-1:0] src_ien_i,
    input logic [NSRC-1:0] wr_set_i,
    input logic [NSRC-1:0] wr_clr_i,
    input logic            rd_stb_i,
    input logic [VW-1:0]   vec_o,
    input logic [NSRC-1:0] flags_o,
    input logic            irq_o
);
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_o & src_ien_i) == '0) |-> (vec_o == '0)); // R2
    AST_PENDING_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_o & src_ien_i) != '0) |-> (vec_o != '0)); // R3
    AST_IRQ_HAS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vec_o != '0)); // R8
    AST_READ_CLEARS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && flags_o[0] && src_ien_i[0] && !src_set_i[0] && !wr_set_i[0])
        |=> !flags_o[0]); // R5
    AST_READ_ONE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && wr_clr_i == '0)
        |=> ($countones(flags_o & $past(flags_o)) + 1 >= $countones($past(flags_o)))); // R5
    AST_MASKED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr_i == '0)
        |=> ((($past(flags_o) & ~$past(src_ien_i)) & ~flags_o) == '0)); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set_i != '0) |=> ((flags_o & $past(src_set_i)) == $past(src_set_i))); // R9
endmodule

bind ivr_vector_reg ivr_vector_reg_chk #(.NSRC(NUM_CH + 1), .VW($clog2(OVF_CODE + 1))) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_set_i (src_set_i),
    .src_ien_i (src_ien_i),
    .wr_set_i  (wr_set_i),
    .wr_clr_i  (wr_clr_i),
    .rd_stb_i  (rd_stb_i),
    .vec_o     (vec_o),
    .flags_o   (flags_o),
    .irq_o     (irq_o)
);

// File: tb/tb_ivr_vector_reg.sv
module tb_ivr_vector_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] src_set_i = '0, src_ien_i = '0, wr_set_i = '0, wr_clr_i = '0;
    logic       rd_stb_i = 1'b0;
    logic [3:0] vec_o;
    logic [2:0] flags_o;
    logic       irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [2:0] model = '0;

    always #5 clk = ~clk;

    ivr_vector_reg dut (
        .clk (clk), .rst_n (rst_n), .src_set_i (src_set_i), .src_ien_i (src_ien_i),
        .wr_set_i (wr_set_i), .wr_clr_i (wr_clr_i), .rd_stb_i (rd_stb_i),
        .vec_o (vec_o), .flags_o (flags_o), .irq_o (irq_o)
    );

    // Expected code from R3 and R4
    function automatic logic [3:0] exp_vec(logic [2:0] f, logic [2:0] en);
        if (f[0] & en[0]) return 4'd2;
        if (f[1] & en[1]) return 4'd4;
        if (f[2] & en[2]) return 4'd10;
        return 4'd0;
    endfunction

    // Expected next flags from R5, R9, R10
    function automatic logic [2:0] exp_next(logic [2:0] f, logic [2:0] en, logic rd,
                                            logic [2:0] hs, logic [2:0] ws, logic [2:0] wc);
        logic [3:0] v;
        logic [2:0] rc;
        v  = exp_vec(f, en);
        rc = !rd ? 3'b000 : (v == 4'd2) ? 3'b001 : (v == 4'd4) ? 3'b010 :
             (v == 4'd10) ? 3'b100 : 3'b000;
        return (f & ~(wc | rc)) | hs | ws;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: drive after negedge, check outputs, advance model
    task automatic step(logic [2:0] hs, logic [2:0] ws, logic [2:0] wc, logic [2:0] en,
                        logic rd, string tag);
        src_set_i = hs; wr_set_i = ws; wr_clr_i = wc; src_ien_i = en; rd_stb_i = rd;
        #1;
        check({tag, " vec"}, vec_o, exp_vec(model, en));
        check({tag, " irq"}, irq_o, (model & en) != 0);
        model = exp_next(model, en, rd, hs, ws, wc);
        @(posedge clk);
        @(negedge clk);
        check({tag, " flags"}, flags_o, model);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1 flags", flags_o, 0);
        check("R1 vec", vec_o, 0);
        rst_n = 1'b1;
        #1;
        check("R1 irq", irq_o, 0);
        @(negedge clk);
        // R10 set all, then R6 walk with R3/R4 codes; R11 read at zero
        step(3'b000, 3'b111, 3'b000, 3'b111, 1'b0, "R10");
        step(3'b000, 3'b000, 3'b000, 3'b111, 1'b1, "R4");
        step(3'b000, 3'b000, 3'b000, 3'b111, 1'b1, "R3");
        step(3'b000, 3'b000, 3'b000, 3'b111, 1'b1, "R6");
        step(3'b000, 3'b000, 3'b000, 3'b111, 1'b1, "R11");
        step(3'b000, 3'b000, 3'b000, 3'b111, 1'b0, "R8");
        // R7 masked channel 1 is skipped and kept
        step(3'b011, 3'b000, 3'b000, 3'b110, 1'b0, "R7");
        step(3'b000, 3'b000, 3'b000, 3'b110, 1'b1, "R7");
        step(3'b000, 3'b000, 3'b000, 3'b110, 1'b1, "R7");
        step(3'b000, 3'b000, 3'b000, 3'b111, 1'b0, "R2");
        // R9 set collides with read-clear and with write-clear
        step(3'b001, 3'b000, 3'b000, 3'b111, 1'b1, "R9");
        step(3'b001, 3'b000, 3'b001, 3'b111, 1'b0, "R9");
        // R10 write-set beats write-clear; then write-clear alone
        step(3'b000, 3'b100, 3'b100, 3'b111, 1'b0, "R10");
        step(3'b000, 3'b000, 3'b111, 3'b111, 1'b0, "R10");
        step(3'b000, 3'b000, 3'b000, 3'b000, 1'b1, "R2");
        // R5 random mix against the bench model
        for (int i = 0; i < 600; i++) begin
            step(3'($urandom_range(0, 7) & $urandom_range(0, 7)),
                 3'($urandom_range(0, 7) & $urandom_range(0, 7) & $urandom_range(0, 7)),
                 3'($urandom_range(0, 7) & $urandom_range(0, 7) & $urandom_range(0, 7)),
                 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), "R5");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule